// File: doc/BRIEF.md
# Phase Detector with Lock Detection and Pump Control

The block sits between the two divider chains of a frequency synthesiser. It takes single-cycle pulses from the divided VCO path (`div_pls`) and from the divided reference path (`ref_pls`). A phase-frequency detector turns the gap between them into UP and DOWN requests for an external charge pump. A lock monitor measures the phase-error width in every comparison window. While the loop is acquiring, it selects a high pump current. Once the error has stayed small for several windows in a row, it selects a low tracking current and releases the lock pin. The lock pin is active-low: 1 means pull low (out of lock), 0 means let the pin float (locked).

A test decoder can override the pump direction, the pump current and the lock pin. It uses a test enable and three port bits (`tp1`, `tp2`, `tp3`). Two disable inputs idle the pump and turn off the varactor driver. All outputs are digital controls. The analog current sources, the loop amplifier and the open-collector drivers are outside the block.

There is no streaming data path. Every pin is a plain level or single-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: After reset, `pump_up`=0, `pump_dn`=0, `lock_pull`=1, `route_ports`=0 and `cur_sel`=1 (acquisition current).
- R2: When a `ref_pls` pulse precedes a `div_pls` pulse by k cycles, `pump_up` is high for exactly k cycles, starting the cycle after `ref_pls`, and `pump_dn` stays low.
- R3: When `div_pls` precedes `ref_pls` by k cycles, `pump_dn` is high for exactly k cycles. Pulses that arrive in the same cycle produce neither request.
- R4: `pump_up` and `pump_dn` are never high in the same cycle outside the forced test states.
- R5: The error width of a window is the number of cycles with an UP or DOWN request between two `ref_pls` pulses. The window that ends at the first `ref_pls` after reset is not judged. Lock is declared at the `ref_pls` that completes `LOCK_COUNT` (default 8) consecutive judged windows whose error width is at most `LOCK_TOL` (default 4). When lock is declared, `lock_pull` goes to 0 and `cur_sel` goes to 0 (tracking current).
- R6: The first judged window whose error width exceeds `LOCK_TOL` drops lock at that `ref_pls`: `lock_pull`=1 and `cur_sel`=1.
- R7: `pump_dis` forces `pump_up`=`pump_dn`=0 and sets `pump_idle`. `drive_off` follows `drive_dis`.
- R8: With `test_en`=1 and `tp2`=0, the pump is forced and the normal requests are ignored. `tp3`=1 forces up and `tp3`=0 forces down. `tp1`=0 selects `cur_sel`=2 (test current) and `tp1`=1 selects `cur_sel`=0.
- R9: With `test_en`=1, `tp2`=1 and `tp3`=0 (`tp1` ignored), `lock_pull`=1 and `route_ports`=1.
- R10: With `test_en`=1, `tp2`=1 and `tp3`=1 (`tp1` ignored), `lock_pull`=0 whatever the lock state.
- R11: With `test_en`=0, the `tp1`..`tp3` bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low reset |
| ref_pls | input | 1 | Divided reference pulse, one cycle |
| div_pls | input | 1 | Divided VCO pulse, one cycle |
| test_en | input | 1 | Test decoder enable |
| tp1 | input | 1 | Test port bit 1 |
| tp2 | input | 1 | Test port bit 2 |
| tp3 | input | 1 | Test port bit 3 |
| pump_dis | input | 1 | Idle the charge pump |
| drive_dis | input | 1 | Turn off varactor drive |
| pump_up | output | 1 | Source-current request |
| pump_dn | output | 1 | Sink-current request |
| cur_sel | output | 2 | Pump current code: 0 tracking, 1 acquisition, 2 test |
| pump_idle | output | 1 | Pump disabled |
| drive_off | output | 1 | Varactor drive disabled |
| lock_pull | output | 1 | 1 pulls the lock pin low (unlocked), 0 floats it (locked) |
| route_ports | output | 1 | Route comparison pulses to the ports |

## Verification
A detector flop stuck or cleared at the wrong time shows up on `pump_up` or `pump_dn` within the same comparison window, as a pulse whose width differs from the pulse gap. A miscounted error width or consecutive-window count moves the lock edge by at least one whole window. So `lock_pull` and `cur_sel` are checked at the end of every window of a lock sequence, with the exact window where the change must appear. A wrong test decode is visible on the very next sample, because the override paths are combinational.

// File: rtl/pdlock_pkg.sv
package pdlock_pkg;
  typedef enum logic [1:0] {
    CUR_TRACK = 2'd0,
    CUR_ACQ   = 2'd1,
    CUR_TEST  = 2'd2
  } cur_code_e;
endpackage

// File: rtl/pdlock_pfd.sv
module pdlock_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pls,
  input  logic div_pls,
  output logic up_q,
  output logic dn_q
);
  logic up_n, dn_n;

  always_comb begin
    up_n = up_q | ref_pls;
    dn_n = dn_q | div_pls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_n && dn_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  // R4
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up_q && dn_q));

  // R3
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pls && div_pls && !up_q && !dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/pdlock_lockdet.sv
module pdlock_lockdet #(
  parameter int ERR_W      = 8,
  parameter int LOCK_TOL   = 4,
  parameter int LOCK_COUNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pls,
  input  logic busy,
  output logic locked
);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ERR_W-1:0]  err_cnt;
  logic [ERR_W:0]    err_total;
  logic [GOOD_W-1:0] good_cnt;
  logic              armed;
  logic              bad_win;

  always_comb begin
    err_total = {1'b0, err_cnt} + (ERR_W + 1)'(busy);
    bad_win   = err_total > (ERR_W + 1)'(LOCK_TOL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      good_cnt <= '0;
      armed    <= 1'b0;
      locked   <= 1'b0;
    end else if (ref_pls) begin
      err_cnt <= '0;
      armed   <= 1'b1;
      if (armed) begin
        if (bad_win) begin
          good_cnt <= '0;
          locked   <= 1'b0;
        end else if (good_cnt != GOOD_W'(LOCK_COUNT)) begin
          good_cnt <= good_cnt + 1'b1;
          if (good_cnt == GOOD_W'(LOCK_COUNT - 1)) locked <= 1'b1;
        end
      end
    end else if (busy && err_cnt != ERR_MAX) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  // R5
  lock_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_pls));

  // R6
  bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pls && armed && bad_win) |=> !locked);
endmodule

// File: rtl/pdlock_ctrl.sv
module pdlock_ctrl
  import pdlock_pkg::*;
(
  input  logic       up_q,
  input  logic       dn_q,
  input  logic       locked,
  input  logic       test_en,
  input  logic       tp1,
  input  logic       tp2,
  input  logic       tp3,
  input  logic       pump_dis,
  output logic       pump_up,
  output logic       pump_dn,
  output cur_code_e  cur_sel,
  output logic       lock_pull,
  output logic       route_ports
);
  logic force_pump, force_lock, up_raw, dn_raw;

  always_comb begin
    force_pump = test_en && !tp2;
    force_lock = test_en && tp2;
    if (force_pump) begin
      up_raw  = tp3;
      dn_raw  = !tp3;
      cur_sel = tp1 ? CUR_TRACK : CUR_TEST;
    end else begin
      up_raw  = up_q;
      dn_raw  = dn_q;
      cur_sel = locked ? CUR_TRACK : CUR_ACQ;
    end
    pump_up     = up_raw && !pump_dis;
    pump_dn     = dn_raw && !pump_dis;
    lock_pull   = force_lock ? !tp3 : !locked;
    route_ports = force_lock && !tp3;
  end
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl #(
  parameter int ERR_W      = 8,
  parameter int LOCK_TOL   = 4,
  parameter int LOCK_COUNT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_pls,
  input  logic       div_pls,
  input  logic       test_en,
  input  logic       tp1,
  input  logic       tp2,
  input  logic       tp3,
  input  logic       pump_dis,
  input  logic       drive_dis,
  output logic       pump_up,
  output logic       pump_dn,
  output logic [1:0] cur_sel,
  output logic       pump_idle,
  output logic       drive_off,
  output logic       lock_pull,
  output logic       route_ports
);
  import pdlock_pkg::*;

  logic      up_q, dn_q, locked;
  cur_code_e cur_code;

  pdlock_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .div_pls(div_pls),
    .up_q(up_q), .dn_q(dn_q)
  );

  pdlock_lockdet #(.ERR_W(ERR_W), .LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .busy(up_q | dn_q),
    .locked(locked)
  );

  pdlock_ctrl u_ctrl (
    .up_q(up_q), .dn_q(dn_q), .locked(locked), .test_en(test_en),
    .tp1(tp1), .tp2(tp2), .tp3(tp3), .pump_dis(pump_dis),
    .pump_up(pump_up), .pump_dn(pump_dn), .cur_sel(cur_code),
    .lock_pull(lock_pull), .route_ports(route_ports)
  );

  assign cur_sel   = cur_code;
  assign pump_idle = pump_dis;
  assign drive_off = drive_dis;

  // R7
  pump_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pump_dis |-> (!pump_up && !pump_dn));

  // R10
  force_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && tp2 && tp3) |-> !lock_pull);

  // R9
  route_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_ports |-> lock_pull);

  // R11
  normal_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> !route_ports);
endmodule

// File: tb/pfd_lock_ctrl_bench.sv
module pfd_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pls = 0, div_pls = 0, test_en = 0, tp1 = 0, tp2 = 0, tp3 = 0;
  logic pump_dis = 0, drive_dis = 0;
  logic pump_up, pump_dn, pump_idle, drive_off, lock_pull, route_ports;
  logic [1:0] cur_sel;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pfd_lock_ctrl u_pfd_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .div_pls(div_pls),
    .test_en(test_en), .tp1(tp1), .tp2(tp2), .tp3(tp3),
    .pump_dis(pump_dis), .drive_dis(drive_dis),
    .pump_up(pump_up), .pump_dn(pump_dn), .cur_sel(cur_sel),
    .pump_idle(pump_idle), .drive_off(drive_off),
    .lock_pull(lock_pull), .route_ports(route_ports)
  );

  // {ref cycle, div cycle, expected up width, expected down width}
  localparam int VEC [6][4] = '{
    '{0, 3, 3, 0}, '{0, 1, 1, 0}, '{2, 0, 0, 2},
    '{0, 0, 0, 0}, '{0, 7, 7, 0}, '{5, 1, 0, 4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic period(input int ref_at, input int div_at, input int len,
                        output int ups, output int dns, output int both);
    ups = 0; dns = 0; both = 0;
    for (int c = 0; c < len; c++) begin
      ups  += int'(pump_up);
      dns  += int'(pump_dn);
      both += int'(pump_up && pump_dn);
      ref_pls = (c == ref_at);
      div_pls = (c == div_at);
      @(negedge clk);
    end
    ref_pls = 0; div_pls = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int u, d, b;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 up", int'(pump_up), 0);
    chk("R1 dn", int'(pump_dn), 0);
    chk("R1 lock_pull", int'(lock_pull), 1);
    chk("R1 cur_sel", int'(cur_sel), 1);
    chk("R1 route", int'(route_ports), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 vector table
    for (int i = 0; i < 6; i++) begin
      period(VEC[i][0], VEC[i][1], 12, u, d, b);
      chk($sformatf("R2 up width vec%0d", i), u, VEC[i][2]);
      chk($sformatf("R3 dn width vec%0d", i), d, VEC[i][3]);
      chk($sformatf("R4 overlap vec%0d", i), b, 0);
    end

    // R5 lock sequence at the tolerance boundary (width 4)
    do_reset();
    for (int p = 1; p <= 9; p++) begin
      period(0, 4, 12, u, d, b);
      if (p == 8) chk("R5 not yet locked", int'(lock_pull), 1);
      if (p == 8) chk("R5 acq current", int'(cur_sel), 1);
    end
    chk("R5 locked pin", int'(lock_pull), 0);
    chk("R5 tracking current", int'(cur_sel), 0);

    // R11 port bits ignored outside test mode
    tp1 = 1; tp2 = 1; tp3 = 0;
    @(negedge clk);
    chk("R11 lock_pull", int'(lock_pull), 0);
    chk("R11 route", int'(route_ports), 0);
    chk("R11 up", int'(pump_up), 0);
    chk("R11 cur", int'(cur_sel), 0);

    // R9 forced unlock while locked
    test_en = 1;
    @(negedge clk);
    chk("R9 lock_pull", int'(lock_pull), 1);
    chk("R9 route", int'(route_ports), 1);
    tp1 = 0;
    @(negedge clk);
    chk("R9 tp1 ignored", int'(lock_pull), 1);
    // R10 forced lock
    tp3 = 1;
    @(negedge clk);
    chk("R10 lock_pull", int'(lock_pull), 0);
    chk("R10 route", int'(route_ports), 0);
    test_en = 0; tp1 = 0; tp2 = 0; tp3 = 0;
    @(negedge clk);

    // R6 a single bad window drops lock
    period(0, 6, 12, u, d, b);
    chk("R6 still locked before judge", int'(lock_pull), 0);
    period(0, 2, 12, u, d, b);
    chk("R6 lock dropped", int'(lock_pull), 1);
    chk("R6 acq current", int'(cur_sel), 1);

    // R10 forced lock while unlocked
    test_en = 1; tp2 = 1; tp3 = 1; tp1 = 1;
    @(negedge clk);
    chk("R10 unlocked forced", int'(lock_pull), 0);

    // R8 forced pump states
    tp2 = 0; tp1 = 0; tp3 = 0;
    @(negedge clk);
    chk("R8 000 dn", int'(pump_dn), 1);
    chk("R8 000 up", int'(pump_up), 0);
    chk("R8 000 cur", int'(cur_sel), 2);
    chk("R8 000 lock normal", int'(lock_pull), 1);
    tp3 = 1;
    @(negedge clk);
    chk("R8 001 up", int'(pump_up), 1);
    chk("R8 001 cur", int'(cur_sel), 2);
    tp1 = 1; tp3 = 0;
    @(negedge clk);
    chk("R8 100 dn", int'(pump_dn), 1);
    chk("R8 100 cur", int'(cur_sel), 0);
    tp3 = 1;
    @(negedge clk);
    chk("R8 101 up", int'(pump_up), 1);
    chk("R8 101 dn", int'(pump_dn), 0);
    chk("R8 101 cur", int'(cur_sel), 0);

    // R7 disable masks even the forced state
    pump_dis = 1; drive_dis = 1;
    @(negedge clk);
    chk("R7 forced up masked", int'(pump_up), 0);
    chk("R7 idle", int'(pump_idle), 1);
    chk("R7 drive off", int'(drive_off), 1);
    test_en = 0; tp1 = 0; tp3 = 0;
    period(0, 3, 12, u, d, b);
    chk("R7 up masked", u, 0);
    chk("R7 dn masked", d, 0);
    pump_dis = 0; drive_dis = 0;
    @(negedge clk);
    chk("R7 idle clear", int'(pump_idle), 0);
    chk("R7 drive on", int'(drive_off), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule